// File: doc/BRIEF.md
# SD Host Command Engine

This block is the command half of an SD card host controller. Software programs a 32-bit argument word and then writes a 16-bit command word. The command word carries a 6-bit command index, direction hints, response-type flags and a start bit. Setting the start bit launches the command on a card-side request port. That port runs a level start/done handshake and returns the response bytes, the response length and a failure flag.

On completion the block checks the returned length against the response type the command asked for. A mismatch, or a failure reported by the card port, is flagged as a command timeout. A valid response is repacked into four 32-bit response words. A host status register collects events and is cleared by writing ones. A single interrupt line is derived from its interrupt-class bits. CRC, serial line timing, clock division and timeout counting belong to other blocks.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is low and `card_start_o` is low.
- R2: A write to the command register (address 0) with bit 15 set starts a command. `card_start_o` rises the next cycle and stays high until the cycle in which `card_done_i` is sampled high. While it is high, `card_index_o` equals command bits 5:0 and `card_arg_o` equals the argument register (address 1).
- R3: Command bit 15 reads back as 1 while a command is in flight and clears once the command completes. A command write with bit 15 clear only stores the value (readable at address 0) and starts nothing.
- R4: When bit 10 (no response) is clear, a completion is an error if the length is 0, if the length is 4 while bit 9 (long) is set, or if the length is neither 4 nor 16. A card-port failure is an error whatever the flags. On error, command bit 14 is set, status bit 6 is set, and the response words keep their old values.
- R5: A valid 4-byte response goes to response word 0 (address 4) with byte 0 as the most significant byte. Words 1 to 3 (addresses 5 to 7) become zero. Byte 0 is presented on `card_resp_i[127:120]`.
- R6: A valid 16-byte response is stored in reverse word order. Bytes 12..15 go to word 0, bytes 8..11 to word 1, bytes 4..7 to word 2 and bytes 0..3 to word 3. Each word is big-endian, and byte k sits at `card_resp_i[127-8k -: 8]`.
- R7: With bit 10 set, the returned length is ignored, no length error is raised and the response words are left unchanged.
- R8: A completion without error of a command with bit 11 (busy-wait) sets status bit 10, but only if bit 10 of the configuration register (address 3) is set.
- R9: Writing the status register (address 2) clears exactly the bits written as 1 and leaves the others.
- R10: `irq_o` is high exactly when any of status bits 10, 9 or 8 is set, and it falls in the cycle after the clearing write.
- R11: Writes to the command and argument registers while a command is in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| card_start_o | output | 1 | Command request, held until done |
| card_index_o | output | 6 | Command index to the card port |
| card_arg_o | output | 32 | Command argument to the card port |
| card_done_i | input | 1 | Card port completion pulse |
| card_len_i | input | 5 | Response length in bytes |
| card_err_i | input | 1 | Card port failure |
| card_resp_i | input | 128 | Response bytes, byte 0 in the top bits |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words, four response words and a 5-bit length field. That length field can carry every value from 0 to 31, so the random lengths reach all the invalid sizes as well as 0, 4 and 16. The four response words are enough to show the reverse word order of long responses and the zeroing of the upper words on short ones. Random mixes of response flags, card failures, busy-wait enables and status clears are combined with directed cases for each length rule and for writes made while a command is in flight.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int CMD_W = 16;
  localparam int IDX_W = 6;

  // register word addresses
  localparam int A_CMD  = 0;
  localparam int A_ARG  = 1;
  localparam int A_STAT = 2;
  localparam int A_CFG  = 3;
  localparam int A_RSP  = 4;

  // status / config bit positions
  localparam int ST_TIMEOUT = 6;
  localparam int ST_BUSY    = 10;
  localparam int CF_BUSY_EN = 10;

  typedef struct packed {
    logic             go;
    logic             fail;
    logic [1:0]       rsv_hi;
    logic             busy_wait;
    logic             no_rsp;
    logic             long_rsp;
    logic             rsv_mid;
    logic             wr;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/sd_cmd_rsp_check.sv
module sd_cmd_rsp_check #(
  parameter int DATA_W    = 32,
  parameter int RSP_WORDS = 4,
  parameter int LEN_W     = 5
) (
  input  logic                          long_rsp_i,
  input  logic                          no_rsp_i,
  input  logic                          card_err_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic [RSP_WORDS*DATA_W-1:0]   resp_i,
  output logic                          err_o,
  output logic [RSP_WORDS-1:0][DATA_W-1:0] words_o
);
  localparam int SHORT_B = DATA_W / 8;
  localparam int LONG_B  = RSP_WORDS * DATA_W / 8;
  localparam int TOP     = RSP_WORDS * DATA_W;

  logic is_short, is_long, len_bad;

  assign is_short = (len_i == LEN_W'(SHORT_B));
  assign is_long  = (len_i == LEN_W'(LONG_B));
  assign len_bad  = (len_i == '0) || (is_short && long_rsp_i) || !(is_short || is_long);
  assign err_o    = card_err_i || (!no_rsp_i && len_bad);

  // long: last bytes land in word 0; short: first bytes land in word 0
  for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
    if (k == 0) begin : g_w0
      assign words_o[k] = is_long ? resp_i[0 +: DATA_W] : resp_i[TOP-1 -: DATA_W];
    end else begin : g_wn
      assign words_o[k] = is_long ? resp_i[k*DATA_W +: DATA_W] : '0;
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic done_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            busy_q <= 1'b0;
    else if (busy_q)        busy_q <= !done_i;
    else if (go_i)          busy_q <= 1'b1;
  end

  assign busy_o = busy_q;

  p_start_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i |=> busy_q);
  p_issue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && go_i |=> busy_q);
  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && done_i |=> !busy_q);
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int RSP_WORDS = 4,
  parameter int LEN_W     = 5,
  parameter int STAT_W    = 11,
  parameter int CFG_W     = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]           reg_wdata_i,
  output logic [DATA_W-1:0]           reg_rdata_o,
  output logic                        card_start_o,
  output logic [IDX_W-1:0]            card_index_o,
  output logic [DATA_W-1:0]           card_arg_o,
  input  logic                        card_done_i,
  input  logic [LEN_W-1:0]            card_len_i,
  input  logic                        card_err_i,
  input  logic [RSP_WORDS*DATA_W-1:0] card_resp_i,
  output logic                        irq_o
);
  cmd_t                              cmd_q;
  logic [DATA_W-1:0]                 arg_q;
  logic [STAT_W-1:0]                 stat_q, stat_set, stat_clr;
  logic [CFG_W-1:0]                  cfg_q;
  logic [RSP_WORDS-1:0][DATA_W-1:0]  rsp_q, rsp_new;
  logic busy, done_ev, rsp_err, go;
  logic wr_cmd, wr_arg, wr_stat, wr_cfg;

  assign wr_cmd  = reg_we_i && reg_addr_i == ADDR_W'(A_CMD);
  assign wr_arg  = reg_we_i && reg_addr_i == ADDR_W'(A_ARG);
  assign wr_stat = reg_we_i && reg_addr_i == ADDR_W'(A_STAT);
  assign wr_cfg  = reg_we_i && reg_addr_i == ADDR_W'(A_CFG);
  assign go      = wr_cmd && !busy && reg_wdata_i[CMD_W-1];
  assign done_ev = busy && card_done_i;

  sd_cmd_issue u_issue (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .done_i(card_done_i),
    .busy_o(busy)
  );

  sd_cmd_rsp_check #(
    .DATA_W(DATA_W), .RSP_WORDS(RSP_WORDS), .LEN_W(LEN_W)
  ) u_chk (
    .long_rsp_i(cmd_q.long_rsp),
    .no_rsp_i  (cmd_q.no_rsp),
    .card_err_i(card_err_i),
    .len_i     (card_len_i),
    .resp_i    (card_resp_i),
    .err_o     (rsp_err),
    .words_o   (rsp_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      arg_q <= '0;
    end else if (done_ev) begin
      cmd_q.go <= 1'b0;
      if (rsp_err) cmd_q.fail <= 1'b1;
    end else if (!busy) begin
      if (wr_cmd) cmd_q <= cmd_t'(reg_wdata_i[CMD_W-1:0]);
      if (wr_arg) arg_q <= reg_wdata_i;
    end
  end

  always_comb begin
    stat_set = '0;
    stat_clr = wr_stat ? reg_wdata_i[STAT_W-1:0] : '0;
    if (done_ev) begin
      if (rsp_err)                                   stat_set[ST_TIMEOUT] = 1'b1;
      else if (cmd_q.busy_wait && cfg_q[CF_BUSY_EN]) stat_set[ST_BUSY]    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      cfg_q  <= '0;
      rsp_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      if (wr_cfg) cfg_q <= reg_wdata_i[CFG_W-1:0];
      if (done_ev && !rsp_err && !cmd_q.no_rsp) rsp_q <= rsp_new;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_CMD))       reg_rdata_o[CMD_W-1:0]  = cmd_q;
    else if (reg_addr_i == ADDR_W'(A_ARG))  reg_rdata_o             = arg_q;
    else if (reg_addr_i == ADDR_W'(A_STAT)) reg_rdata_o[STAT_W-1:0] = stat_q;
    else if (reg_addr_i == ADDR_W'(A_CFG))  reg_rdata_o[CFG_W-1:0]  = cfg_q;
    else begin
      for (int k = 0; k < RSP_WORDS; k++)
        if (int'(reg_addr_i) == A_RSP + k) reg_rdata_o = rsp_q[k];
    end
  end

  assign card_start_o = busy;
  assign card_index_o = cmd_q.idx;
  assign card_arg_o   = arg_q;
  assign irq_o        = |stat_q[STAT_W-1:8];

  p_req_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_start_o && !card_done_i |=> $stable(card_index_o) && $stable(card_arg_o));
  p_go_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_start_o && card_done_i |=> !cmd_q.go);
  p_fail_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ev && rsp_err |=> cmd_q.fail && stat_q[ST_TIMEOUT]);
  p_err_keeps_rsp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_ev && rsp_err |=> $stable(rsp_q));
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && reg_wdata_i[ST_BUSY] && !done_ev |=> !stat_q[ST_BUSY]);
  p_irq_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && (&reg_wdata_i[STAT_W-1:8]) |=> !irq_o);
endmodule

// File: tb/sd_cmd_engine_bench.sv
`timescale 1ns/1ps
module sd_cmd_engine_bench;
  logic         clk = 0, rst_n = 0;
  logic         we = 0;
  logic [2:0]   addr = 0;
  logic [31:0]  wdata = 0, rdata;
  logic         start, done = 0, cerr = 0, irq;
  logic [5:0]   idx;
  logic [31:0]  arg;
  logic [4:0]   len = 0;
  logic [127:0] resp = 0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] exp_rsp [4];
  logic [10:0] exp_stat;
  logic        cfg_en;

  always #10 clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .card_start_o(start),
    .card_index_o(idx), .card_arg_o(arg), .card_done_i(done),
    .card_len_i(len), .card_err_i(cerr), .card_resp_i(resp), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic bit exp_err(logic [15:0] c, logic [4:0] l, logic ce);
    if (ce) return 1;
    if (c[10]) return 0;
    return (l == 0) || (l == 4 && c[9]) || (l != 4 && l != 16);
  endfunction

  function automatic logic [31:0] exp_word(int k, logic [4:0] l, logic [127:0] r);
    if (l == 16) return r[k*32 +: 32];
    return (k == 0) ? r[127:96] : 32'h0;
  endfunction

  task automatic check_regs(string tag, logic [15:0] exp_cmd);
    logic [31:0] d;
    rd(0, d); check({tag, " cmd"}, d, {16'h0, exp_cmd});
    rd(2, d); check({tag, " status"}, d, {21'h0, exp_stat});
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), d); check({tag, " rsp"}, d, exp_rsp[k]);
    end
    check({tag, " R10 irq"}, {31'h0, irq}, {31'h0, |exp_stat[10:8]});
  endtask

  task automatic run_cmd(logic [15:0] c, logic [31:0] a, logic [4:0] l, logic ce,
                         logic [127:0] r, int dly, bit poke);
    logic [31:0] d;
    bit e;
    wr(1, a);
    len = l; cerr = ce; resp = r;
    wr(0, {16'h0, c | 16'h8000});
    check("R2 start", {31'h0, start}, 32'h1);
    check("R2 index", {26'h0, idx}, {26'h0, c[5:0]});
    check("R2 arg", arg, a);
    rd(0, d); check("R3 go set in flight", {31'h0, d[15]}, 32'h1);
    if (poke) begin
      wr(0, 32'h0000_8000 | 32'(~c[5:0]));
      wr(1, ~a);
      check("R11 index held", {26'h0, idx}, {26'h0, c[5:0]});
      check("R11 arg held", arg, a);
      check("R2 start held", {31'h0, start}, 32'h1);
    end
    repeat (dly) @(negedge clk);
    done = 1;
    @(negedge clk); done = 0;
    check("R2 start drops", {31'h0, start}, 32'h0);
    e = exp_err(c, l, ce);
    if (e) exp_stat[6] = 1;
    else begin
      if (!c[10]) for (int k = 0; k < 4; k++) exp_rsp[k] = exp_word(k, l, r);
      if (c[11] && cfg_en) exp_stat[10] = 1;
    end
    check_regs("R3 R4 R5 R6 R7 R8", (c & 16'h7fff) | (e ? 16'h4000 : 16'h0));
    rd(1, d); check("R11 arg reg", d, a);
  endtask

  task automatic set_cfg(logic en);
    cfg_en = en;
    wr(3, en ? 32'h400 : 32'h0);
  endtask

  task automatic clr_stat(logic [10:0] m);
    wr(2, {21'h0, m});
    exp_stat &= ~m;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 4; k++) exp_rsp[k] = 0;
    exp_stat = 0; cfg_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); check("R1 reset reg", d, 0);
    end
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 start", {31'h0, start}, 0);

    // R3: store only
    wr(0, 32'h0000_0245);
    check("R3 no start", {31'h0, start}, 0);
    repeat (2) @(negedge clk);
    check("R3 still no start", {31'h0, start}, 0);
    rd(0, d); check("R3 stored", d, 32'h245);

    // R5 short, R6 long
    run_cmd(16'h0011, 32'hdead_beef, 4, 0, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff, 2, 0);
    run_cmd(16'h0202, 32'h1, 16, 0, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff, 0, 1);
    // R4 error cases
    run_cmd(16'h0203, 32'h2, 4, 0, rnd128(), 1, 0);
    run_cmd(16'h0004, 32'h3, 0, 0, rnd128(), 1, 0);
    run_cmd(16'h0005, 32'h4, 8, 0, rnd128(), 1, 0);
    run_cmd(16'h0006, 32'h5, 4, 1, rnd128(), 1, 0);
    run_cmd(16'h0406, 32'h5, 16, 1, rnd128(), 1, 0);
    // R7 no response ignores length
    run_cmd(16'h0407, 32'h6, 0, 0, rnd128(), 1, 0);
    run_cmd(16'h0607, 32'h6, 9, 0, rnd128(), 0, 0);
    // R8 busy-wait gated by config
    run_cmd(16'h0c08, 32'h7, 0, 0, rnd128(), 1, 0);
    set_cfg(1);
    run_cmd(16'h0c09, 32'h8, 0, 0, rnd128(), 1, 0);
    check("R10 irq high", {31'h0, irq}, 1);
    // R9 clear only timeout, irq stays
    clr_stat(11'h040);
    check_regs("R9 partial clear", 16'h0c09);
    clr_stat(11'h400);
    check_regs("R9 R10 clear busy", 16'h0c09);

    // random
    for (int i = 0; i < 300; i++) begin
      logic [15:0] c;
      logic [4:0]  l;
      int sel;
      c = 16'($urandom) & 16'h7eff;
      c[10] = ($urandom % 4 == 0);
      sel = $urandom % 8;
      l = (sel == 0) ? 5'd0 : (sel < 4 || sel == 7) ? 5'd4 : (sel < 6) ? 5'd16 : 5'($urandom);
      if ($urandom % 10 == 0) set_cfg(1'($urandom));
      if ($urandom % 4 == 0) clr_stat(11'($urandom));
      run_cmd(c, $urandom, l, ($urandom % 8 == 0), rnd128(), $urandom % 4, ($urandom % 5 == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule